// File: doc/BRIEF.md
# Auto-Ranging Gated Frequency Counter

This block measures the rate of a conditioned, clock-synchronous digital input by counting its high-to-low transitions inside a gate window that it times itself from the system clock. The input is sampled once every `SAMPLE_DIV` system clocks. A transition is counted only when one sample is high and the next sample is low, so the fastest countable input runs at one transition per two samples.

Each measurement sequence begins with the shortest gate, `BASE_GATE` clocks. When a window closes, the block checks whether the count reached `MIN_COUNT`, which is three significant decimal digits by default. If it did, the block publishes the count and the index of the gate decade that produced it. If it did not, the gate is made ten times longer and the measurement is repeated, up to `NUM_RANGES` decades. If even the longest gate gives too few transitions, the block pulses a request asking the surrounding system to switch to period measurement. Either outcome starts a new sequence at once, so the block measures continuously.

The defaults suit a 12 MHz clock: sampling every 12 clocks, gates of 10 ms, 100 ms and 1 s, and a 16-bit saturating counter.

Top module: `fc_autorange`

## Requirements
- R1: The input is sampled when a free-running divider reaches the last of its `SAMPLE_DIV` steps. The divider is 0 at reset, so the first sample is taken at the `SAMPLE_DIV`-th clock edge. One transition is counted when the stored sample is 1 and the new sample is 0. The stored sample is 0 after reset.
- R2: Every attempt has three phases. It spends one clock clearing the counter, then holds the window open for exactly `BASE_GATE`·10^r clocks (r is the current decade index), then spends one clock on evaluation. Transitions are counted only while the window is open.
- R3: The transition counter saturates at 2^`CNT_W`−1 and never wraps. A saturated count is treated as a result at the current gate.
- R4: After reset, after every published result and after every period request, the next attempt uses decade index 0, the shortest gate.
- R5: If the count at evaluation is at least `MIN_COUNT`, `measValid` pulses high for one clock. In that same clock, `measCount` carries the count and `measRange` carries the decade index, where 0 is the shortest gate.
- R6: If the count is below `MIN_COUNT` and the decade index is not the last one, no output pulses. The next attempt uses the next decade index, which has a gate ten times longer.
- R7: If the count is below `MIN_COUNT` at the last decade index, `periodReq` pulses high for one clock and `measValid` stays low. The two pulses never occur in the same clock.
- R8: Synchronous reset drives `measCount`, `measRange`, `measValid` and `periodReq` to 0. `measCount` and `measRange` keep their values until the next `measValid`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| sigIn | input | 1 | Conditioned input signal, synchronous to clk |
| measCount | output | CNT_W | Transition count of the last accepted window |
| measRange | output | RANGE_W | Decade index of the gate behind measCount |
| measValid | output | 1 | One-clock strobe marking a new result |
| periodReq | output | 1 | One-clock request to fall back to period measurement |

## Verification
Two kinds of coincidence need care. A sampled falling transition can land on the last open clock of a window, on the clear clock, or on the evaluation clock. A transition can also arrive in the same clock that the counter reaches its ceiling. These coincidences are provoked by input periods that do not divide the gate length, so the phase of the input drifts against the window boundaries from one attempt to the next. A narrow counter makes saturation reachable at every decade. A behavioural model steps through the same sampling and gating rules one clock at a time. Every output is compared with this model on every clock, so a transition counted one clock early or late shows up as a mismatch in the count.

// File: rtl/fc_pkg.sv
package fc_pkg;

  // Strobes from the range controller to the edge datapath.
  typedef struct packed {
    logic clear;    // zero the transition counter
    logic countEn;  // gate window open
  } fcStrobe_t;

  typedef enum logic [1:0] {
    ST_CLEAR = 2'd0,
    ST_OPEN  = 2'd1,
    ST_EVAL  = 2'd2
  } fcState_t;

endpackage

// File: rtl/fc_edge_datapath.sv
module fc_edge_datapath
  import fc_pkg::*;
#(
  parameter int SAMPLE_DIV = 12,
  parameter int CNT_W      = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sigIn,
  input  fcStrobe_t        strb,
  output logic [CNT_W-1:0] edgeCount
);

  localparam int DIV_W = (SAMPLE_DIV > 1) ? $clog2(SAMPLE_DIV) : 1;
  localparam logic [DIV_W-1:0] DIV_LAST = DIV_W'(SAMPLE_DIV - 1);
  localparam logic [CNT_W-1:0] CNT_MAX  = '1;

  logic [DIV_W-1:0] divCnt;
  logic             sampleTick;
  logic             lastSample;
  logic             fallEdge;

  assign sampleTick = (divCnt == DIV_LAST);

  always_ff @(posedge clk) begin
    if (rst)             divCnt <= '0;
    else if (sampleTick) divCnt <= '0;
    else                 divCnt <= divCnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst)             lastSample <= 1'b0;
    else if (sampleTick) lastSample <= sigIn;
  end

  // Previous sample high and current sample low.
  assign fallEdge = sampleTick && lastSample && !sigIn;

  always_ff @(posedge clk) begin
    if (rst)
      edgeCount <= '0;
    else if (strb.clear)
      edgeCount <= '0;
    else if (strb.countEn && fallEdge && (edgeCount != CNT_MAX))
      edgeCount <= edgeCount + 1'b1;
  end

  // R3
  cnt_saturate_chk: assert property (@(posedge clk) disable iff (rst)
    (edgeCount == CNT_MAX && !strb.clear) |=> (edgeCount == CNT_MAX));

  // R1
  edge_step_chk: assert property (@(posedge clk) disable iff (rst)
    !strb.clear |=> (edgeCount == $past(edgeCount) ||
                     edgeCount == $past(edgeCount) + 1'b1));

  // R2
  gate_closed_chk: assert property (@(posedge clk) disable iff (rst)
    (!strb.countEn && !strb.clear) |=> (edgeCount == $past(edgeCount)));

endmodule

// File: rtl/fc_range_ctrl.sv
module fc_range_ctrl
  import fc_pkg::*;
#(
  parameter int BASE_GATE  = 120000,
  parameter int NUM_RANGES = 3,
  parameter int MIN_COUNT  = 100,
  parameter int CNT_W      = 16,
  parameter int RANGE_W    = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [CNT_W-1:0]   edgeCount,
  output fcStrobe_t          strb,
  output logic [CNT_W-1:0]   measCount,
  output logic [RANGE_W-1:0] measRange,
  output logic               measValid,
  output logic               periodReq
);

  localparam int unsigned GATE_MAX = BASE_GATE * (10 ** (NUM_RANGES - 1));
  localparam int TMR_W = (GATE_MAX > 2) ? $clog2(GATE_MAX) : 1;
  localparam logic [RANGE_W-1:0] LAST_RANGE = RANGE_W'(NUM_RANGES - 1);
  localparam logic [CNT_W-1:0]   MIN_CNT    = CNT_W'(MIN_COUNT);

  fcState_t           state;
  logic [RANGE_W-1:0] rangeIdx;
  logic [TMR_W-1:0]   gateTmr;
  logic               enough;

  function automatic logic [TMR_W-1:0] gateLast(input logic [RANGE_W-1:0] r);
    int unsigned g = BASE_GATE;
    for (int i = 0; i < NUM_RANGES - 1; i++)
      if (i < int'(r)) g = g * 10;
    return TMR_W'(g - 1);
  endfunction

  assign enough       = (edgeCount >= MIN_CNT);
  assign strb.clear   = (state == ST_CLEAR);
  assign strb.countEn = (state == ST_OPEN);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_CLEAR;
      rangeIdx  <= '0;
      gateTmr   <= '0;
      measCount <= '0;
      measRange <= '0;
      measValid <= 1'b0;
      periodReq <= 1'b0;
    end else begin
      measValid <= 1'b0;
      periodReq <= 1'b0;
      case (state)
        ST_CLEAR: begin
          gateTmr <= gateLast(rangeIdx);
          state   <= ST_OPEN;
        end
        ST_OPEN: begin
          if (gateTmr == '0) state <= ST_EVAL;
          else               gateTmr <= gateTmr - 1'b1;
        end
        ST_EVAL: begin
          state <= ST_CLEAR;
          if (enough) begin
            measValid <= 1'b1;
            measCount <= edgeCount;
            measRange <= rangeIdx;
            rangeIdx  <= '0;
          end else if (rangeIdx == LAST_RANGE) begin
            periodReq <= 1'b1;
            rangeIdx  <= '0;
          end else begin
            rangeIdx  <= rangeIdx + 1'b1;
          end
        end
        default: state <= ST_CLEAR;
      endcase
    end
  end

  // R5
  valid_digits_chk: assert property (@(posedge clk) disable iff (rst)
    measValid |-> (measCount >= MIN_CNT));

  // R7
  pulse_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(measValid && periodReq));

  // R7
  fallback_last_chk: assert property (@(posedge clk) disable iff (rst)
    periodReq |-> ($past(rangeIdx) == LAST_RANGE));

  // R4
  restart_chk: assert property (@(posedge clk) disable iff (rst)
    (measValid || periodReq) |-> (rangeIdx == '0));

  // R6
  widen_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_EVAL && !enough && rangeIdx != LAST_RANGE)
      |=> (rangeIdx == $past(rangeIdx) + 1'b1));

  // R2
  open_after_clear_chk: assert property (@(posedge clk) disable iff (rst)
    strb.clear |=> strb.countEn);

endmodule

// File: rtl/fc_autorange.sv
module fc_autorange
  import fc_pkg::*;
#(
  parameter int SAMPLE_DIV = 12,
  parameter int BASE_GATE  = 120000,
  parameter int NUM_RANGES = 3,
  parameter int MIN_COUNT  = 100,
  parameter int CNT_W      = 16,
  localparam int RANGE_W   = (NUM_RANGES > 1) ? $clog2(NUM_RANGES) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               sigIn,
  output logic [CNT_W-1:0]   measCount,
  output logic [RANGE_W-1:0] measRange,
  output logic               measValid,
  output logic               periodReq
);

  fcStrobe_t        strb;
  logic [CNT_W-1:0] edgeCount;

  fc_edge_datapath #(
    .SAMPLE_DIV(SAMPLE_DIV),
    .CNT_W     (CNT_W)
  ) u_dp (
    .clk      (clk),
    .rst      (rst),
    .sigIn    (sigIn),
    .strb     (strb),
    .edgeCount(edgeCount)
  );

  fc_range_ctrl #(
    .BASE_GATE (BASE_GATE),
    .NUM_RANGES(NUM_RANGES),
    .MIN_COUNT (MIN_COUNT),
    .CNT_W     (CNT_W),
    .RANGE_W   (RANGE_W)
  ) u_ctrl (
    .clk      (clk),
    .rst      (rst),
    .edgeCount(edgeCount),
    .strb     (strb),
    .measCount(measCount),
    .measRange(measRange),
    .measValid(measValid),
    .periodReq(periodReq)
  );

endmodule

// File: tb/fc_autorange_bench.sv
`timescale 1ns/1ps
module fc_autorange_bench;

  localparam int SD   = 2;
  localparam int BG   = 600;
  localparam int NR   = 3;
  localparam int MINC = 100;
  localparam int CW   = 7;
  localparam int CMAX = (1 << CW) - 1;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       sigIn = 1'b0;
  logic [CW-1:0] measCount;
  logic [1:0] measRange;
  logic       measValid;
  logic       periodReq;

  always #2.5 clk = ~clk;

  fc_autorange #(
    .SAMPLE_DIV(SD), .BASE_GATE(BG), .NUM_RANGES(NR),
    .MIN_COUNT(MINC), .CNT_W(CW)
  ) u_fc_autorange (
    .clk(clk), .rst(rst), .sigIn(sigIn),
    .measCount(measCount), .measRange(measRange),
    .measValid(measValid), .periodReq(periodReq)
  );

  int checks = 0;
  int fails  = 0;

  task automatic check(input bit ok, input string req, input string what,
                       input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  // Stimulus generator settings
  int  hiLen = 2, loLen = 2;
  bit  holdLow = 1'b1;
  int  genPh = 0;

  // Behavioural reference model
  int mDiv, mCnt, mState, mRange, mTmr, mOutCnt, mOutRange;
  bit mSmp, mValid, mReq, started;

  function automatic int gateOf(input int r);
    int g = BG;
    for (int i = 0; i < r; i++) g = g * 10;
    return g;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      mDiv = 0; mCnt = 0; mState = 0; mRange = 0; mTmr = 0;
      mOutCnt = 0; mOutRange = 0; mSmp = 0; mValid = 0; mReq = 0;
      started = 1'b1;
    end else begin
      bit tick, fe;
      int oldCnt, oldState;
      tick = (mDiv == SD - 1);
      fe = tick && mSmp && !sigIn;
      oldCnt = mCnt;
      oldState = mState;
      mValid = 0; mReq = 0;
      if (oldState == 0) mCnt = 0;
      else if (oldState == 1 && fe && mCnt < CMAX) mCnt = mCnt + 1;
      case (oldState)
        0: begin mTmr = gateOf(mRange) - 1; mState = 1; end
        1: begin if (mTmr == 0) mState = 2; else mTmr = mTmr - 1; end
        default: begin
          mState = 0;
          if (oldCnt >= MINC) begin
            mValid = 1; mOutCnt = oldCnt; mOutRange = mRange; mRange = 0;
          end else if (mRange == NR - 1) begin
            mReq = 1; mRange = 0;
          end else mRange = mRange + 1;
        end
      endcase
      if (tick) begin mSmp = sigIn; mDiv = 0; end
      else mDiv = mDiv + 1;
    end
  end

  // Per-clock comparison and result capture
  int validSeen = 0, reqSeen = 0, lastCnt = 0, lastRng = 0;

  always @(negedge clk) begin
    if (started) begin
      check(measValid == mValid, "R5", "measValid", int'(measValid), int'(mValid));
      check(periodReq == mReq, "R7", "periodReq", int'(periodReq), int'(mReq));
      check(int'(measCount) == mOutCnt, "R1", "measCount", int'(measCount), mOutCnt);
      check(int'(measRange) == mOutRange, "R6", "measRange", int'(measRange), mOutRange);
      if (measValid) begin
        validSeen++; lastCnt = int'(measCount); lastRng = int'(measRange);
      end
      if (periodReq) reqSeen++;
    end
  end

  task automatic runScenario(input int hi, input int lo, input bit low,
                             input int needValid);
    @(negedge clk);
    rst = 1'b1; hiLen = hi; loLen = lo; holdLow = low; genPh = 0;
    repeat (3) @(negedge clk);
    validSeen = 0; reqSeen = 0;
    rst = 1'b0;
    while (validSeen < needValid && reqSeen == 0) @(negedge clk);
  endtask

  task automatic summary;
    $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    fork
      forever begin
        @(negedge clk);
        if (holdLow) sigIn = 1'b0;
        else sigIn = (genPh < hiLen);
        genPh = (genPh + 1 >= hiLen + loLen) ? 0 : genPh + 1;
      end
    join_none

    // R8: reset state
    repeat (3) @(negedge clk);
    check(measValid == 1'b0, "R8", "reset measValid", int'(measValid), 0);
    check(periodReq == 1'b0, "R8", "reset periodReq", int'(periodReq), 0);
    check(measCount == '0, "R8", "reset measCount", int'(measCount), 0);

    // R3: fastest input saturates at the shortest gate; R4: second result also range 0
    runScenario(2, 2, 1'b0, 2);
    check(lastRng == 0, "R4", "fast range", lastRng, 0);
    check(lastCnt == CMAX, "R3", "fast saturated count", lastCnt, CMAX);
    check(reqSeen == 0, "R7", "fast no request", reqSeen, 0);

    // R5: one edge per period, about 120, above the threshold and unsaturated
    runScenario(2, 3, 1'b0, 1);
    check(lastRng == 0, "R5", "period5 range", lastRng, 0);
    check(lastCnt >= MINC && lastCnt < CMAX, "R5", "period5 count", lastCnt, 120);

    // R6: one widening step
    runScenario(20, 20, 1'b0, 1);
    check(lastRng == 1, "R6", "period40 range", lastRng, 1);
    check(lastCnt == CMAX, "R3", "period40 count", lastCnt, CMAX);

    // R6/R2: widest gate reached
    runScenario(200, 200, 1'b0, 1);
    check(lastRng == 2, "R6", "period400 range", lastRng, 2);
    check(lastCnt == CMAX, "R2", "period400 count", lastCnt, CMAX);
    check(reqSeen == 0, "R7", "period400 no request", reqSeen, 0);

    // R7: no transitions at all -> fallback request, no result
    runScenario(1, 1, 1'b1, 1);
    check(reqSeen == 1, "R7", "fallback request", reqSeen, 1);
    check(validSeen == 0, "R7", "fallback no valid", validSeen, 0);
    check(measCount == '0, "R8", "count held after fallback", int'(measCount), 0);

    // R4: restart at shortest gate after fallback (model compares every clock)
    repeat (BG + 10) @(negedge clk);
    check(reqSeen == 1, "R4", "no second request yet", reqSeen, 1);

    summary();
  end

  initial begin
    repeat (180000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL R4 watchdog expired actual=%0d expected=%0d", 1, 0);
    summary();
  end

endmodule